// File: doc/BRIEF.md
# Four-Lane GHASH Engine with Rotated-Replay Fault Check

This block computes the GHASH polynomial hash over GF(2^128) with Q parallel lanes (four by default). Each accepted group carries Q consecutive 128-bit blocks: associated data, ciphertext and the final length block, which the surrounding logic has already formed. Every lane keeps a running value that is folded with its new block and multiplied by H^Q once per group. After the last group, lane l is weighted by H^(Q-l) and all lanes are summed into the hash. The caller supplies the first Q powers of the hash subkey.

Faults are caught by time redundancy. The message is streamed twice. In the first pass each block goes to its own lane. In the replay every block is moved SHIFT lanes further round the ring. The sum over all lanes of the lane values, taken at the final group, does not depend on which lane handled which column. The first pass stores this sum, and the replay must reproduce it exactly. The weighting step then runs twice on identical operands, and the two results are compared. An OR over every input bit of the first pass is reported, because a message that is zero everywhere gives no coverage under rotation.

Top module: `ghash_par_chk`

## Requirements
- R1: After reset, blk_ready, done and err are low.
- R2: At done, hash equals the sum over i of X_i·H^(n-i+1) for n = (groups)·Q. Bit j of a 128-bit value is the coefficient of x^j, and reduction uses x^128 = x^7+x^2+x+1. Lane l of blk_data (bits l·128 upward) carries block X_(kQ+l+1) of group k. Lane j of hpow carries H^(j+1).
- R3: blk_ready is high only in the two streaming passes. A group is taken on a clock edge with blk_valid and blk_ready both high. A taken group with blk_last set ends a pass. The caller sends the whole message, then sends the same groups again.
- R4: done is high for exactly one cycle, the third cycle after the replay's last group is taken. hash is valid in that cycle and stays unchanged until the weighting of the next message.
- R5: err is cleared when start is taken in the idle state. Otherwise err only rises: it keeps its value after done and while idle.
- R6: err is high at done if a lane's multiplier product is corrupted throughout the message (multi-group message).
- R7: If the two weighting passes disagree, err is high at done, and hash keeps the result of the first weighting pass.
- R8: With fault-free logic, err is low at done for any message, including one with a single group.
- R9: all_zero at done is high exactly when every bit of every first-pass block was zero.
- R10: Cycles with blk_valid low (whatever blk_data and blk_last hold), inputs while idle without start, and start outside the idle state all leave the hash and the control flow unchanged.
- R11: With H = x^27+x^25+x^20+x^4+x+1 and the four-block message (0, 0, x^89+x^23+x^10, x^93+x^24+x^10+x), hash has exactly the terms x^120,118,113,94,93,91,89,77,73,64,63,60,51,50,49,44,37,35,31,30,26,24,23,22,21,17,16,15,14,13,8,5,3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a message (honoured only when idle) |
| blk_valid | input | 1 | A group is presented on blk_data |
| blk_last | input | 1 | The presented group is the last of its pass |
| blk_data | input | Q·128 | Q blocks, lane l at bits l·128 upward |
| hpow | input | Q·128 | Powers H^1..H^Q, lane j = H^(j+1) |
| blk_ready | output | 1 | Block accepts a group this cycle |
| hash | output | 128 | GHASH result, valid with done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky mismatch flag |
| all_zero | output | 1 | First pass had no set input bit, valid with done |

## Verification
Two functions share one clock edge when the first pass ends. The intermediate sum is captured and the lanes are cleared, and the first replayed group arrives in the very next cycle. The bench provokes this by streaming both passes back to back with no idle cycle, and it judges the outcome from a hash that matches a serial Horner model with err low. The second overlap is in the final weighting: the comparison that can raise err runs in the same cycle in which hash must hold the first pass's value. A product corrupted only in that cycle must give a correct hash together with a raised err.

// File: rtl/ghp_pkg.sv
package ghp_pkg;
  localparam int GF_W = 128;
  localparam logic [GF_W-1:0] GF_RED = 128'h87;

  typedef logic [GF_W-1:0] gf_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN_N = 3'd1,
    ST_RUN_S = 3'd2,
    ST_FIN_A = 3'd3,
    ST_FIN_B = 3'd4,
    ST_DONE  = 3'd5
  } ghp_state_e;
endpackage

// File: rtl/gf128_mul.sv
module gf128_mul
  import ghp_pkg::*;
(
  input  gf_t op_a,
  input  gf_t op_b,
  output gf_t prod
);
  gf_t acc;
  gf_t shf;

  // shift-and-add over the bits of op_b; shf holds op_a * x^i mod f
  always_comb begin
    acc = '0;
    shf = op_a;
    for (int i = 0; i < GF_W; i++) begin
      if (op_b[i]) acc = acc ^ shf;
      shf = {shf[GF_W-2:0], 1'b0} ^ (shf[GF_W-1] ? GF_RED : '0);
    end
  end

  assign prod = acc;
endmodule

// File: rtl/ghp_branch.sv
module ghp_branch
  import ghp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd_mul,
  input  logic upd_add,
  input  logic sel_fin,
  input  gf_t  blk,
  input  gf_t  hq,
  input  gf_t  wgt,
  output gf_t  mix,
  output gf_t  prod
);
  gf_t  acc_q;
  gf_t  acc_d;
  logic acc_en;
  gf_t  op_a;
  gf_t  op_b;
  gf_t  mul_out;

  assign op_a = sel_fin ? acc_q : (acc_q ^ blk);
  assign op_b = sel_fin ? wgt : hq;

  gf128_mul u_mul (
    .op_a (op_a),
    .op_b (op_b),
    .prod (mul_out)
  );

  assign acc_en = clr | upd_mul | upd_add;

  always_comb begin
    if (clr)          acc_d = '0;
    else if (upd_add) acc_d = acc_q ^ blk;
    else              acc_d = mul_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign mix  = acc_q ^ blk;
  assign prod = mul_out;
endmodule

// File: rtl/ghp_ctrl.sv
module ghp_ctrl
  import ghp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic blk_valid,
  input  logic blk_last,
  output logic ready,
  output logic go,
  output logic br_clr,
  output logic upd_mul,
  output logic upd_add,
  output logic swap,
  output logic sel_fin,
  output logic cap_int,
  output logic cmp_int,
  output logic cap_res,
  output logic cmp_res,
  output logic note_blk,
  output logic done
);
  ghp_state_e st_q;
  ghp_state_e st_d;
  logic       take_n;
  logic       take_s;

  assign take_n = (st_q == ST_RUN_N) & blk_valid;
  assign take_s = (st_q == ST_RUN_S) & blk_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_RUN_N;
      ST_RUN_N: if (blk_valid && blk_last) st_d = ST_RUN_S;
      ST_RUN_S: if (blk_valid && blk_last) st_d = ST_FIN_A;
      ST_FIN_A: st_d = ST_FIN_B;
      ST_FIN_B: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign ready    = (st_q == ST_RUN_N) | (st_q == ST_RUN_S);
  assign go       = (st_q == ST_IDLE) & start;
  assign br_clr   = go | (take_n & blk_last);
  assign upd_mul  = (take_n | take_s) & ~blk_last;
  assign upd_add  = take_s & blk_last;
  assign swap     = (st_q == ST_RUN_S);
  assign sel_fin  = (st_q == ST_FIN_A) | (st_q == ST_FIN_B);
  assign cap_int  = take_n & blk_last;
  assign cmp_int  = take_s & blk_last;
  assign cap_res  = (st_q == ST_FIN_A);
  assign cmp_res  = (st_q == ST_FIN_B);
  assign note_blk = take_n;
  assign done     = (st_q == ST_DONE);
endmodule

// File: rtl/ghash_par_chk.sv
module ghash_par_chk
  import ghp_pkg::*;
#(
  parameter int Q     = 4,
  parameter int SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              blk_valid,
  input  logic              blk_last,
  input  logic [Q*GF_W-1:0] blk_data,
  input  logic [Q*GF_W-1:0] hpow,
  output logic              blk_ready,
  output logic [GF_W-1:0]   hash,
  output logic              done,
  output logic              err,
  output logic              all_zero
);
  localparam int ROT = ((SHIFT % Q) + Q) % Q;

  logic go, br_clr, upd_mul, upd_add, swap, sel_fin;
  logic cap_int, cmp_int, cap_res, cmp_res, note_blk;

  gf_t mix_w  [Q];
  gf_t prod_w [Q];
  gf_t mix_x;
  gf_t prod_x;
  gf_t hq;

  gf_t  int_q, int_d;
  gf_t  res_q, res_d;
  logic err_q, err_d;
  logic any_q, any_d;

  ghp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .blk_valid (blk_valid),
    .blk_last  (blk_last),
    .ready     (blk_ready),
    .go        (go),
    .br_clr    (br_clr),
    .upd_mul   (upd_mul),
    .upd_add   (upd_add),
    .swap      (swap),
    .sel_fin   (sel_fin),
    .cap_int   (cap_int),
    .cmp_int   (cmp_int),
    .cap_res   (cap_res),
    .cmp_res   (cmp_res),
    .note_blk  (note_blk),
    .done      (done)
  );

  assign hq = hpow[(Q-1)*GF_W +: GF_W];

  // branch b handles lane b in the first pass and lane (b-ROT) mod Q in the replay;
  // weighting follows the lane held after the replay
  for (genvar gb = 0; gb < Q; gb++) begin : g_br
    localparam int LANE = (gb - ROT + Q) % Q;
    localparam int WIDX = Q - 1 - LANE;
    gf_t lane_in;

    assign lane_in = swap ? blk_data[LANE*GF_W +: GF_W] : blk_data[gb*GF_W +: GF_W];

    ghp_branch u_br (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (br_clr),
      .upd_mul (upd_mul),
      .upd_add (upd_add),
      .sel_fin (sel_fin),
      .blk     (lane_in),
      .hq      (hq),
      .wgt     (hpow[WIDX*GF_W +: GF_W]),
      .mix     (mix_w[gb]),
      .prod    (prod_w[gb])
    );
  end

  always_comb begin
    mix_x  = '0;
    prod_x = '0;
    for (int b = 0; b < Q; b++) begin
      mix_x  = mix_x ^ mix_w[b];
      prod_x = prod_x ^ prod_w[b];
    end
  end

  always_comb begin
    int_d = cap_int ? mix_x : int_q;
    res_d = cap_res ? prod_x : res_q;
    err_d = err_q;
    if (go) err_d = 1'b0;
    else if ((cmp_int && (mix_x != int_q)) || (cmp_res && (prod_x != res_q))) err_d = 1'b1;
    any_d = any_q;
    if (go) any_d = 1'b0;
    else if (note_blk) any_d = any_q | (|blk_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= '0;
      res_q <= '0;
      err_q <= 1'b0;
      any_q <= 1'b0;
    end else begin
      if (cap_int)                 int_q <= int_d;
      if (cap_res)                 res_q <= res_d;
      if (go | cmp_int | cmp_res)  err_q <= err_d;
      if (go | note_blk)           any_q <= any_d;
    end
  end

  assign hash     = res_q;
  assign err      = err_q;
  assign all_zero = ~any_q;
endmodule

// File: rtl/ghash_par_chk_sva.sv
module ghash_par_chk_sva #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         blk_valid,
  input logic         blk_last,
  input logic         blk_ready,
  input logic [W-1:0] hash,
  input logic         done,
  input logic         err
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_DONE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !blk_ready); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err); // R5

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(blk_valid && blk_ready && blk_last, 3)); // R4

  AST_HASH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> $stable(hash)); // R4
endmodule

bind ghash_par_chk ghash_par_chk_sva #(.W(128)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .blk_valid (blk_valid),
  .blk_last  (blk_last),
  .blk_ready (blk_ready),
  .hash      (hash),
  .done      (done),
  .err       (err)
);

// File: tb/ghash_par_chk_tb.sv
module ghash_par_chk_tb;
  localparam int Q = 4;
  localparam int W = 128;
  typedef logic [W-1:0] v_t;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic           blk_valid;
  logic           blk_last;
  logic [Q*W-1:0] blk_data;
  logic [Q*W-1:0] hpow;
  logic           blk_ready;
  v_t             hash;
  logic           done;
  logic           err;
  logic           all_zero;

  int  n_chk;
  int  n_fail;
  bit  fin;
  logic [63:0] rs;
  v_t  hkey;
  v_t  msg[$];

  ghash_par_chk #(.Q(Q), .SHIFT(1)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .blk_valid (blk_valid),
    .blk_last  (blk_last),
    .blk_data  (blk_data),
    .hpow      (hpow),
    .blk_ready (blk_ready),
    .hash      (hash),
    .done      (done),
    .err       (err),
    .all_zero  (all_zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Horner from the top coefficient of b
  function automatic v_t ref_mul(input v_t a, input v_t b);
    v_t r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = r[W-1] ? ({r[W-2:0], 1'b0} ^ 128'h87) : {r[W-2:0], 1'b0};
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic v_t rnd();
    v_t o;
    for (int h = 0; h < 2; h++) begin
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 7);
      rs = rs ^ (rs << 17);
      o[h*64 +: 64] = rs;
    end
    return o;
  endfunction

  function automatic v_t ref_hash();
    v_t y = '0;
    foreach (msg[i]) y = ref_mul(y ^ msg[i], hkey);
    return y;
  endfunction

  task automatic set_key(input v_t h);
    v_t p = h;
    hkey = h;
    for (int j = 0; j < Q; j++) begin
      hpow[j*W +: W] = p;
      p = ref_mul(p, h);
    end
  endtask

  task automatic chk(input bit ok, input string req, input v_t act, input v_t exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int nblk, input bit zero);
    msg.delete();
    for (int i = 0; i < nblk; i++) msg.push_back(zero ? '0 : rnd());
  endtask

  // fault_kind: 0 none, 1 branch-1 product stuck at zero all message, 2 corrupted in second weighting cycle
  task automatic run_msg(input int gap, input int fault_kind, input bit exp_err, input bit chk_h);
    int  g = msg.size() / Q;
    v_t  exp_h = ref_hash();
    bit  exp_z = 1'b1;
    foreach (msg[i]) if (msg[i] != '0) exp_z = 1'b0;
    if (fault_kind == 1) force u_dut.g_br[1].u_br.mul_out = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err == 1'b0, "R5 err cleared by start", v_t'(err), '0);
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < g; k++) begin
        if (gap > 0 && k == 1) begin
          for (int c = 0; c < gap; c++) begin
            blk_valid = 1'b0;
            blk_last  = 1'b1;
            start     = 1'b1;
            for (int l = 0; l < Q; l++) blk_data[l*W +: W] = rnd();
            chk(blk_ready == 1'b1, "R3 ready while streaming", v_t'(blk_ready), 1);
            @(negedge clk);
          end
          start = 1'b0;
        end
        blk_valid = 1'b1;
        blk_last  = (k == g - 1);
        for (int l = 0; l < Q; l++) blk_data[l*W +: W] = msg[k*Q + l];
        chk(blk_ready == 1'b1, "R3 ready while streaming", v_t'(blk_ready), 1);
        chk(done == 1'b0, "R4 no done while streaming", v_t'(done), 0);
        @(negedge clk);
      end
    end
    blk_valid = 1'b0;
    blk_last  = 1'b0;
    chk(blk_ready == 1'b0, "R3 ready low after replay", v_t'(blk_ready), 0);
    chk(done == 1'b0, "R4 done not yet (1)", v_t'(done), 0);
    @(negedge clk);
    if (fault_kind == 2) force u_dut.g_br[1].u_br.mul_out = '0;
    chk(done == 1'b0, "R4 done not yet (2)", v_t'(done), 0);
    @(negedge clk);
    if (fault_kind == 2) release u_dut.g_br[1].u_br.mul_out;
    chk(done == 1'b1, "R4 done pulse", v_t'(done), 1);
    chk(err == exp_err, exp_err ? "R6/R7 err raised" : "R8 err low", v_t'(err), v_t'(exp_err));
    chk(all_zero == exp_z, "R9 all_zero", v_t'(all_zero), v_t'(exp_z));
    if (chk_h) chk(hash == exp_h, "R2 hash vs serial model", hash, exp_h);
    @(negedge clk);
    if (fault_kind == 1) release u_dut.g_br[1].u_br.mul_out;
    chk(done == 1'b0, "R4 done one cycle", v_t'(done), 0);
    chk(blk_ready == 1'b0, "R3 ready low when idle", v_t'(blk_ready), 0);
    if (chk_h) chk(hash == exp_h, "R4 hash held", hash, exp_h);
  endtask

  initial begin
    fin = 1'b0;
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int kat_t[] = '{120,118,113,94,93,91,89,77,73,64,63,60,51,50,49,44,37,35,
                    31,30,26,24,23,22,21,17,16,15,14,13,8,5,3};
    v_t kat_h, kat_a, kat_b, kat_r;
    n_chk = 0;
    n_fail = 0;
    rs = 64'h9E37_79B9_7F4A_7C15;
    rst_n = 1'b0;
    start = 1'b0;
    blk_valid = 1'b0;
    blk_last = 1'b0;
    blk_data = '0;
    set_key(rnd());
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(blk_ready == 1'b0, "R1 ready after reset", v_t'(blk_ready), 0);
    chk(done == 1'b0, "R1 done after reset", v_t'(done), 0);
    chk(err == 1'b0, "R1 err after reset", v_t'(err), 0);

    // R10: activity while idle without start
    blk_valid = 1'b1;
    blk_last = 1'b1;
    blk_data = {rnd(), rnd(), rnd(), rnd()};
    repeat (4) begin
      @(negedge clk);
      chk(blk_ready == 1'b0 && done == 1'b0, "R10 idle inputs ignored", v_t'({blk_ready, done}), 0);
    end
    blk_valid = 1'b0;
    blk_last = 1'b0;

    // R2 R8: back-to-back passes, several groups
    fill(4 * Q, 1'b0);
    run_msg(0, 0, 1'b0, 1'b1);

    // R11 known answer
    kat_h = '0; kat_a = '0; kat_b = '0; kat_r = '0;
    kat_h[27] = 1; kat_h[25] = 1; kat_h[20] = 1; kat_h[4] = 1; kat_h[1] = 1; kat_h[0] = 1;
    kat_a[89] = 1; kat_a[23] = 1; kat_a[10] = 1;
    kat_b[93] = 1; kat_b[24] = 1; kat_b[10] = 1; kat_b[1] = 1;
    foreach (kat_t[i]) kat_r[kat_t[i]] = 1'b1;
    set_key(kat_h);
    msg.delete();
    msg.push_back('0); msg.push_back('0); msg.push_back(kat_a); msg.push_back(kat_b);
    chk(ref_hash() == kat_r, "R11 bench model known answer", ref_hash(), kat_r);
    run_msg(0, 0, 1'b0, 1'b1);
    chk(hash == kat_r, "R11 known answer", hash, kat_r);

    // R2 R8 single group
    set_key(rnd());
    fill(Q, 1'b0);
    run_msg(0, 0, 1'b0, 1'b1);

    // R10: idle cycles with junk and start pulses mid-stream
    fill(5 * Q, 1'b0);
    run_msg(3, 0, 1'b0, 1'b1);

    // R9 all-zero message
    fill(3 * Q, 1'b1);
    run_msg(0, 0, 1'b0, 1'b1);
    chk(hash == '0, "R9 zero message hash", hash, '0);

    // R6 stuck product in one branch
    fill(4 * Q, 1'b0);
    run_msg(0, 1, 1'b1, 1'b0);
    @(negedge clk);
    chk(err == 1'b1, "R5 err sticky while idle", v_t'(err), 1);

    // R5 R8 clean message after fault clears err
    fill(2 * Q, 1'b0);
    run_msg(1, 0, 1'b0, 1'b1);

    // R7 corruption in second weighting cycle only
    fill(3 * Q, 1'b0);
    run_msg(0, 2, 1'b1, 1'b1);

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule